// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

A synchronous memory of 4096 sixteen-bit words with two fully independent ports. Each port has its own select, write strobe, read enable, upper-half and lower-half byte enables, address, write data and a write-block input. The write-block input comes from an external collision arbiter. Reads are registered: the selected halves of the addressed word appear one clock after the request, along with a valid flag.

The two highest word addresses also act as mailboxes between the ports. When one port writes the mailbox that belongs to the other port, that port's active-low mail flag drops. The receiving port raises its flag again by touching its own mailbox with the read enable asserted, whether or not it writes at the same time. Port A owns word 0xFFE and port B owns word 0xFFF. The words themselves are ordinary storage, and their contents play no part in the flag logic.

Top module: `dpm_top`

## Requirements
- R1: A read request (select=1, write=0, read enable=1, at least one byte enable=1) sampled on a clock edge returns the addressed word on rdata and sets rvalid=1 after that same edge. Both change on that edge and on no later one.
- R2: The upper byte enable governs bits 15:8 and the lower byte enable governs bits 7:0, for both writes and reads. A half that is not enabled is left unchanged on a write and reads back as zero.
- R3: rvalid stays 0 when select=0, read enable=0, write=1, or both byte enables are 0. A port with select=0 writes nothing.
- R4: With its write-block input at 1, a port's writes leave memory unchanged, while its reads still complete normally.
- R5: A read on one port and a write on the other port to the same address in the same cycle return the old word.
- R6: A write (select=1, write=1, not blocked) by port B to 0xFFE drives a_mail_n low after the edge. A write by port A to 0xFFF drives b_mail_n low. Byte enables do not matter for this.
- R7: Port A accessing 0xFFE with select=1 and read enable=1 sets a_mail_n high; port B does the same with 0xFFF. The write input does not matter. Without read enable, the flag is not cleared.
- R8: When the acting port has write-block=1, neither a post nor a clear changes the mail flag.
- R9: If a post and a clear of the same flag fall in the same cycle, the flag ends low.
- R10: After reset, a_mail_n=1, b_mail_n=1, a_rvalid=0 and b_rvalid=0.
- R11: A mailbox word keeps the data written to it, and that data can be read like any other word.
- R12: If both ports write the same enabled half of one address in one cycle, port A's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_sel | input | 1 | Port A select |
| a_write | input | 1 | Port A write strobe (1 = write) |
| a_rden | input | 1 | Port A read enable |
| a_hi_en | input | 1 | Port A enable for bits 15:8 |
| a_lo_en | input | 1 | Port A enable for bits 7:0 |
| a_wr_block | input | 1 | Port A write block from the arbiter |
| a_addr | input | 12 | Port A word address |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A read data |
| a_rvalid | output | 1 | Port A read data valid |
| a_mail_n | output | 1 | Port A mail flag, active low |
| b_sel | input | 1 | Port B select |
| b_write | input | 1 | Port B write strobe (1 = write) |
| b_rden | input | 1 | Port B read enable |
| b_hi_en | input | 1 | Port B enable for bits 15:8 |
| b_lo_en | input | 1 | Port B enable for bits 7:0 |
| b_wr_block | input | 1 | Port B write block from the arbiter |
| b_addr | input | 12 | Port B word address |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B read data |
| b_rvalid | output | 1 | Port B read data valid |
| b_mail_n | output | 1 | Port B mail flag, active low |

## Verification
Two flag events can land on the same mail flag in one cycle. One port posts to the other's mailbox while the receiving port reads that same word to clear its flag. The bench first lowers the flag, then drives the post and the clearing read together, and expects the flag to stay low. It also expects the read to return the word as it stood before the write. A clearing read alone must then raise the flag, which shows that the earlier low level came from the post winning.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    localparam int NPORT = 2;

    // memory-side decode of one port
    typedef struct packed {
        logic       wr_go;
        logic       rd_go;
        logic [1:0] bmask;   // [1] upper half, [0] lower half
    } mem_ctl_t;

    // mailbox-side decode of one port
    typedef struct packed {
        logic post;      // unblocked write, byte enables ignored
        logic peek;      // unblocked access with read enable
        logic at_own;    // address equals this port's mailbox
        logic at_peer;   // address equals the other port's mailbox
    } box_ctl_t;

endpackage

// File: rtl/dpm_port_decode.sv
module dpm_port_decode
    import dpm_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int PORT_ID = 0
) (
    input  logic              sel,
    input  logic              write,
    input  logic              rden,
    input  logic              hi_en,
    input  logic              lo_en,
    input  logic              wr_block,
    input  logic [ADDR_W-1:0] addr,
    output mem_ctl_t          mctl,
    output box_ctl_t          bctl
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] OWN_BOX  = ADDR_W'(DEPTH - 2 + PORT_ID);
    localparam logic [ADDR_W-1:0] PEER_BOX = ADDR_W'(DEPTH - 1 - PORT_ID);

    logic any_byte;

    always_comb begin
        any_byte     = hi_en | lo_en;
        mctl.bmask   = {hi_en, lo_en};
        mctl.wr_go   = sel & write & any_byte & ~wr_block;
        mctl.rd_go   = sel & ~write & rden & any_byte;
        bctl.post    = sel & write & ~wr_block;
        bctl.peek    = sel & rden & ~wr_block;
        bctl.at_own  = (addr == OWN_BOX);
        bctl.at_peer = (addr == PEER_BOX);
    end

endmodule

// File: rtl/dpm_store.sv
module dpm_store
    import dpm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mem_ctl_t          mctl  [NPORT],
    input  logic [ADDR_W-1:0] addr  [NPORT],
    input  logic [DATA_W-1:0] wdata [NPORT],
    output logic [DATA_W-1:0] rdata [NPORT],
    output logic              rvalid[NPORT]
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int HALF  = DATA_W / 2;

    typedef struct packed {
        logic [NPORT-1:0]             vld;
        logic [NPORT-1:0][DATA_W-1:0] dat;
    } rd_t;

    logic [DATA_W-1:0] mem [DEPTH];
    rd_t rd_d, rd_q;

    // port 0 is written last so it wins an overlapping write
    always_ff @(posedge clk) begin
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (mctl[p].wr_go) begin
                for (int h = 0; h < 2; h++) begin
                    if (mctl[p].bmask[h])
                        mem[addr[p]][h*HALF +: HALF] <= wdata[p][h*HALF +: HALF];
                end
            end
        end
    end

    always_comb begin
        rd_d = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (mctl[p].rd_go) begin
                rd_d.vld[p] = 1'b1;
                for (int h = 0; h < 2; h++) begin
                    if (mctl[p].bmask[h])
                        rd_d.dat[p][h*HALF +: HALF] = mem[addr[p]][h*HALF +: HALF];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_out
        assign rdata[p]  = rd_q.dat[p];
        assign rvalid[p] = rd_q.vld[p];

        // R3
        no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !mctl[p].rd_go |=> !rvalid[p]);
        // R2
        hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mctl[p].rd_go && !mctl[p].bmask[1]) |=> (rdata[p][DATA_W-1:HALF] == '0));
        // R2
        lo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mctl[p].rd_go && !mctl[p].bmask[0]) |=> (rdata[p][HALF-1:0] == '0));
    end

endmodule

// File: rtl/dpm_mailbox.sv
module dpm_mailbox
    import dpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  box_ctl_t         bctl [NPORT],
    output logic [NPORT-1:0] mail_n
);
    typedef struct packed {
        logic [NPORT-1:0] flag_n;
    } mb_t;

    mb_t mb_d, mb_q;
    logic [NPORT-1:0] set_v, clr_v;

    for (genvar p = 0; p < NPORT; p++) begin : g_ev
        assign set_v[p] = bctl[NPORT-1-p].post & bctl[NPORT-1-p].at_peer;
        assign clr_v[p] = bctl[p].peek & bctl[p].at_own;
    end

    always_comb begin
        mb_d = mb_q;
        for (int p = 0; p < NPORT; p++) begin
            if (set_v[p])      mb_d.flag_n[p] = 1'b0;   // post wins
            else if (clr_v[p]) mb_d.flag_n[p] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mb_q <= '{flag_n: '1};
        else        mb_q <= mb_d;
    end

    assign mail_n = mb_q.flag_n;

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        // R6 R9
        post_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[p] |=> !mail_n[p]);
        // R7
        clear_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_v[p] && !set_v[p]) |=> mail_n[p]);
        // R8
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_v[p] && !clr_v[p]) |=> $stable(mail_n[p]));
    end

endmodule

// File: rtl/dpm_top.sv
module dpm_top
    import dpm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_sel,
    input  logic              a_write,
    input  logic              a_rden,
    input  logic              a_hi_en,
    input  logic              a_lo_en,
    input  logic              a_wr_block,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_rvalid,
    output logic              a_mail_n,
    input  logic              b_sel,
    input  logic              b_write,
    input  logic              b_rden,
    input  logic              b_hi_en,
    input  logic              b_lo_en,
    input  logic              b_wr_block,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_rvalid,
    output logic              b_mail_n
);
    logic [NPORT-1:0]  sel_v, write_v, rden_v, hi_v, lo_v, blk_v;
    logic [ADDR_W-1:0] addr_v  [NPORT];
    logic [DATA_W-1:0] wdata_v [NPORT];
    logic [DATA_W-1:0] rdata_v [NPORT];
    logic              rvalid_v[NPORT];
    mem_ctl_t          mctl_v  [NPORT];
    box_ctl_t          bctl_v  [NPORT];
    logic [NPORT-1:0]  mail_v;

    assign sel_v   = {b_sel,      a_sel};
    assign write_v = {b_write,    a_write};
    assign rden_v  = {b_rden,     a_rden};
    assign hi_v    = {b_hi_en,    a_hi_en};
    assign lo_v    = {b_lo_en,    a_lo_en};
    assign blk_v   = {b_wr_block, a_wr_block};
    assign addr_v[0]  = a_addr;
    assign addr_v[1]  = b_addr;
    assign wdata_v[0] = a_wdata;
    assign wdata_v[1] = b_wdata;

    for (genvar p = 0; p < NPORT; p++) begin : g_dec
        dpm_port_decode #(.ADDR_W(ADDR_W), .PORT_ID(p)) dec_i (
            .sel      (sel_v[p]),
            .write    (write_v[p]),
            .rden     (rden_v[p]),
            .hi_en    (hi_v[p]),
            .lo_en    (lo_v[p]),
            .wr_block (blk_v[p]),
            .addr     (addr_v[p]),
            .mctl     (mctl_v[p]),
            .bctl     (bctl_v[p])
        );
    end

    dpm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .mctl   (mctl_v),
        .addr   (addr_v),
        .wdata  (wdata_v),
        .rdata  (rdata_v),
        .rvalid (rvalid_v)
    );

    dpm_mailbox box_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .bctl   (bctl_v),
        .mail_n (mail_v)
    );

    assign a_rdata  = rdata_v[0];
    assign b_rdata  = rdata_v[1];
    assign a_rvalid = rvalid_v[0];
    assign b_rvalid = rvalid_v[1];
    assign a_mail_n = mail_v[0];
    assign b_mail_n = mail_v[1];

endmodule

// File: tb/dpm_top_tb_top.sv
`timescale 1ns/1ps
module dpm_top_tb_top;

    localparam logic [11:0] BOX_A = 12'hFFE;
    localparam logic [11:0] BOX_B = 12'hFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_sel, a_write, a_rden, a_hi_en, a_lo_en, a_wr_block;
    logic b_sel, b_write, b_rden, b_hi_en, b_lo_en, b_wr_block;
    logic [11:0] a_addr, b_addr;
    logic [15:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic a_rvalid, b_rvalid, a_mail_n, b_mail_n;

    always #5 clk = ~clk;

    dpm_top dut_i (.*);

    typedef struct {
        int          due;
        logic [15:0] d;
        string       req;
    } exp_t;

    exp_t qa[$];
    exp_t qb[$];
    logic [15:0] mdl [0:4095];
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    string req = "R1";
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] msk(logic [15:0] d, logic hi, logic lo);
        return {hi ? d[15:8] : 8'h00, lo ? d[7:0] : 8'h00};
    endfunction

    task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic idle();
        {a_sel, a_write, a_rden, a_hi_en, a_lo_en, a_wr_block} = '0;
        {b_sel, b_write, b_rden, b_hi_en, b_lo_en, b_wr_block} = '0;
        a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
    endtask

    task automatic sa(logic s, logic w, logic r, logic hi, logic lo, logic blk,
                      logic [11:0] ad, logic [15:0] d);
        a_sel = s; a_write = w; a_rden = r; a_hi_en = hi; a_lo_en = lo;
        a_wr_block = blk; a_addr = ad; a_wdata = d;
    endtask

    task automatic sb(logic s, logic w, logic r, logic hi, logic lo, logic blk,
                      logic [11:0] ad, logic [15:0] d);
        b_sel = s; b_write = w; b_rden = r; b_hi_en = hi; b_lo_en = lo;
        b_wr_block = blk; b_addr = ad; b_wdata = d;
    endtask

    task automatic mwrite(logic [11:0] ad, logic [15:0] d, logic hi, logic lo);
        if (hi) mdl[ad][15:8] = d[15:8];
        if (lo) mdl[ad][7:0]  = d[7:0];
    endtask

    // driver: predict reads from the model, update the model, clock once
    task automatic fire();
        exp_t e;
        if (a_sel && !a_write && a_rden && (a_hi_en || a_lo_en)) begin
            e.due = cyc + 1; e.d = msk(mdl[a_addr], a_hi_en, a_lo_en); e.req = req;
            qa.push_back(e);
        end
        if (b_sel && !b_write && b_rden && (b_hi_en || b_lo_en)) begin
            e.due = cyc + 1; e.d = msk(mdl[b_addr], b_hi_en, b_lo_en); e.req = req;
            qb.push_back(e);
        end
        if (b_sel && b_write && !b_wr_block) mwrite(b_addr, b_wdata, b_hi_en, b_lo_en);
        if (a_sel && a_write && !a_wr_block) mwrite(a_addr, a_wdata, a_hi_en, a_lo_en);
        @(posedge clk);
        #2;
        idle();
    endtask

    // monitor: compare read results against the scoreboard queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (qa.size() > 0 && qa[0].due == cyc) begin
                chk({qa[0].req, " port A read valid"}, {15'd0, a_rvalid}, 16'd1);
                chk({qa[0].req, " port A read data"}, a_rdata, qa[0].d);
                void'(qa.pop_front());
            end else if (a_rvalid) begin
                chk({req, " port A unexpected rvalid"}, 16'd1, 16'd0);
            end
            if (qb.size() > 0 && qb[0].due == cyc) begin
                chk({qb[0].req, " port B read valid"}, {15'd0, b_rvalid}, 16'd1);
                chk({qb[0].req, " port B read data"}, b_rdata, qb[0].d);
                void'(qb.pop_front());
            end else if (b_rvalid) begin
                chk({req, " port B unexpected rvalid"}, 16'd1, 16'd0);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #2;
        // R10 reset state
        chk("R10 a_mail_n", {15'd0, a_mail_n}, 16'd1);
        chk("R10 b_mail_n", {15'd0, b_mail_n}, 16'd1);
        chk("R10 a_rvalid", {15'd0, a_rvalid}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;

        // R1 full-word write and read on the other port
        req = "R1";
        sa(1,1,0,1,1,0, 12'd5, 16'h1234); fire();
        sb(1,0,1,1,1,0, 12'd5, 16'h0);    fire();
        sa(1,1,0,1,1,0, 12'd6, 16'h0F0F); fire();
        sa(1,0,1,1,1,0, 12'd6, 16'h0);    fire();

        // R2 byte enables on write and read
        req = "R2";
        sa(1,1,0,1,0,0, 12'd5, 16'hABCD); fire();
        sb(1,0,1,0,1,0, 12'd5, 16'h0);    fire();
        sa(1,0,1,1,0,0, 12'd5, 16'h0);    fire();
        sb(1,1,0,0,1,0, 12'd6, 16'h77EE); fire();
        sb(1,0,1,1,1,0, 12'd6, 16'h0);    fire();

        // R3 no read without read enable, deselect or byte enables
        req = "R3";
        sa(1,0,0,1,1,0, 12'd5, 16'h0); fire();
        chk("R3 rvalid with read enable low", {15'd0, a_rvalid}, 16'd0);
        sb(1,0,1,0,0,0, 12'd5, 16'h0); fire();
        chk("R3 rvalid with no byte enable", {15'd0, b_rvalid}, 16'd0);
        sa(0,1,1,1,1,0, 12'd5, 16'hDEAD); fire();
        chk("R3 rvalid when deselected", {15'd0, a_rvalid}, 16'd0);
        sb(1,0,1,1,1,0, 12'd5, 16'h0); fire();

        // R4 blocked write, read still served
        req = "R4";
        sb(1,1,0,1,1,1, 12'd5, 16'h5555); fire();
        sb(1,0,1,1,1,1, 12'd5, 16'h0);    fire();

        // R5 read and opposite write to one address in one cycle
        req = "R5";
        sa(1,1,0,1,1,0, 12'd7, 16'h1111); fire();
        sa(1,1,0,1,1,0, 12'd7, 16'h2222);
        sb(1,0,1,1,1,0, 12'd7, 16'h0);    fire();
        sb(1,0,1,1,1,0, 12'd7, 16'h0);    fire();

        // R12 both ports write the same word
        req = "R12";
        sa(1,1,0,1,1,0, 12'd9, 16'hAAAA);
        sb(1,1,0,1,1,0, 12'd9, 16'hBBBB); fire();
        sa(1,0,1,1,1,0, 12'd9, 16'h0);    fire();

        // R6 / R11 post to A's mailbox, data kept, read clears (R7)
        req = "R6";
        sb(1,1,0,1,1,0, BOX_A, 16'hC0DE); fire();
        chk("R6 a_mail_n after B post", {15'd0, a_mail_n}, 16'd0);
        chk("R6 b_mail_n untouched", {15'd0, b_mail_n}, 16'd1);
        req = "R11";
        sa(1,0,1,1,1,0, BOX_A, 16'h0); fire();
        chk("R7 a_mail_n after A read", {15'd0, a_mail_n}, 16'd1);

        // R7 clear needs read enable; write strobe does not matter
        req = "R7";
        sb(1,1,0,0,1,0, BOX_A, 16'h0042); fire();
        chk("R6 a_mail_n after low-byte post", {15'd0, a_mail_n}, 16'd0);
        sa(1,0,0,1,1,0, BOX_A, 16'h0); fire();
        chk("R7 no clear without read enable", {15'd0, a_mail_n}, 16'd0);
        sa(1,1,1,1,1,0, BOX_A, 16'h9999); fire();
        chk("R7 clear by write with read enable", {15'd0, a_mail_n}, 16'd1);
        sb(1,0,1,1,1,0, BOX_A, 16'h0); fire();

        // R8 blocked poster and blocked reader change nothing
        req = "R8";
        sb(1,1,0,1,1,1, BOX_A, 16'h3333); fire();
        chk("R8 blocked post", {15'd0, a_mail_n}, 16'd1);
        sb(1,1,0,1,1,0, BOX_A, 16'h4444); fire();
        chk("R6 a_mail_n after post", {15'd0, a_mail_n}, 16'd0);
        sa(1,0,1,1,1,1, BOX_A, 16'h0); fire();
        chk("R8 blocked clear", {15'd0, a_mail_n}, 16'd0);
        sa(1,0,1,1,1,0, BOX_A, 16'h0); fire();
        chk("R7 a_mail_n cleared", {15'd0, a_mail_n}, 16'd1);

        // R9 post and clear of B's flag in one cycle
        req = "R9";
        sa(1,1,0,1,1,0, BOX_B, 16'h1001); fire();
        chk("R6 b_mail_n after A post", {15'd0, b_mail_n}, 16'd0);
        chk("R6 a_mail_n untouched", {15'd0, a_mail_n}, 16'd1);
        sa(1,1,0,1,1,0, BOX_B, 16'h2002);
        sb(1,0,1,1,1,0, BOX_B, 16'h0); fire();
        chk("R9 post wins over clear", {15'd0, b_mail_n}, 16'd0);
        sb(1,0,1,1,1,0, BOX_B, 16'h0); fire();
        chk("R7 b_mail_n cleared", {15'd0, b_mail_n}, 16'd1);

        repeat (3) @(posedge clk);
        #2;
        chk("R1 all reads returned", 16'(qa.size() + qb.size()), 16'd0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule